// File: doc/BRIEF.md
# Seven-Counter Event Monitor

This block counts processor events for one core. Seven counters run side by side. Each has an event selector, a few control bits, and logic that detects a wrap. The core feeds the block with single-cycle pulses for retired instructions, instruction-cache reads and misses, and data-cache reads, writes and their misses. It also gives a flag that says the core is in supervisor mode. Counter 0 ignores its selector and counts clock cycles. This gives software a time base to normalise the other counts against.

Software uses a word-wide register port in the 0xC0..0xFC window of a system-control space. One global register starts all counters or zeroes all counters in a single write. Each counter has its own control word and its own value register. A read-only overflow status word shows which counters have wrapped.

When a counter wraps past all-ones it returns to zero and freezes. If its interrupt enable is set, it also posts a status bit. The status bits drive one shared interrupt line. An acknowledge pulse clears the status and releases every frozen counter.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter value, control field and overflow status bit reads 0, and `irqReq` is low.
- R2: The register map is as follows. It decodes only byte addresses 0xC0..0xFC whose two low bits are zero. A read of any other address returns 0.
  - 0xC0: global control.
  - 0xC4: overflow status.
  - 0xC8+4k: local control of counter k.
  - 0xE4+4k: value of counter k.
- R3: A local control word uses these bits:
  - bit 0: enable.
  - bit 1: clear.
  - bit 2: supervisor count.
  - bit 3: interrupt enable.
  - bits 6:4: event select.

  Event code 0 is the cycle count. Code c (1..7) is `evtIn[c-1]`, in this order: instruction, I-cache read, I-cache miss, D-cache read, D-cache read miss, D-cache write, D-cache write miss. An enabled counter adds one on each clock edge where its selected event is high.
- R4: Counter 0 counts every clock edge while enabled, whatever its select field holds.
- R5: A counter whose supervisor-count bit is 0 ignores events while `superMode` is high. With the bit set, it counts in both modes.
- R6: A global-control write with bit 1 set zeroes all counters. A global-control write with bit 0 set sets every enable bit and leaves the other local fields unchanged.
- R7: A local write with the clear bit set zeroes that counter at the next edge, even when an event arrives in the same cycle. The clear bit always reads back as 0.
- R8: A write to a counter's value address loads that value.
- R9: An event on a counter holding all-ones wraps it to 0 and freezes it. A frozen counter ignores further events until an acknowledge arrives.
- R10: An overflow on a counter with interrupt enable set sets status bit k, and `irqReq` is high from the next cycle on. A counter that overflows with interrupt enable clear posts no status.
- R11: An `irqAck` pulse clears all status bits, drops `irqReq` and releases every frozen counter.
- R12: Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 7 | Event pulses for codes 1..7 |
| superMode | input | 1 | Core is in supervisor mode |
| regAddr | input | 8 | Register byte address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| irqReq | output | 1 | Combined overflow interrupt request |

## Verification
The embedded properties assume the following about the inputs:
- Event pulses, register writes and acknowledges each last one cycle.
- An acknowledge does not land in the same cycle as a wrap it is meant to release. When they coincide, the new wrap keeps its freeze.

The bench changes inputs only on falling edges and holds each strobe for exactly one cycle. It raises `irqAck` only in cycles with no event pulse, so a wrap and a release never coincide. It sets wrap conditions by loading all-ones through the value register, not by counting up to it.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_CNT = 7;
  localparam int CNT_W   = 32;
  localparam int SEL_W   = 3;
  localparam int NUM_EVT = 1 << SEL_W;

  // local control bit positions
  localparam int LC_EN      = 0;
  localparam int LC_CLR     = 1;
  localparam int LC_SU      = 2;
  localparam int LC_IRQ     = 3;
  localparam int LC_SEL_LSB = 4;

  // global control bit positions
  localparam int GC_EN  = 0;
  localparam int GC_RST = 1;

  typedef struct packed {
    logic [NUM_CNT-1:0] zero;
    logic [NUM_CNT-1:0] load;
    logic [NUM_CNT-1:0] inc;
  } cntStrobe_t;
endpackage

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int N = NUM_CNT,
  parameter int W = CNT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntStrobe_t          strb,
  input  logic [W-1:0]        loadData,
  output logic [N-1:0][W-1:0] cntVal,
  output logic [N-1:0]        ovf
);
  logic [N-1:0][W-1:0] cntQ;

  for (genvar k = 0; k < N; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cntQ[k] <= '0;
      else if (strb.zero[k])  cntQ[k] <= '0;
      else if (strb.load[k])  cntQ[k] <= loadData;
      else if (strb.inc[k])   cntQ[k] <= cntQ[k] + W'(1);
    end

    assign ovf[k] = strb.inc[k] & (&cntQ[k]) & ~strb.zero[k] & ~strb.load[k];

    AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strb.zero[k] |=> cntQ[k] == '0); // R7
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      ovf[k] |=> cntQ[k] == '0); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
      (strb.inc[k] && !strb.zero[k] && !strb.load[k]) |=> cntQ[k] == W'($past(cntQ[k]) + W'(1))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.inc[k] && !strb.zero[k] && !strb.load[k]) |=> $stable(cntQ[k])); // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (strb.load[k] && !strb.zero[k]) |=> cntQ[k] == $past(loadData)); // R8
  end

  assign cntVal = cntQ;
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int N    = NUM_CNT,
  parameter int W    = CNT_W,
  parameter int SW   = SEL_W,
  parameter int NEVT = NUM_EVT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NEVT-2:0]     evtIn,
  input  logic                superMode,
  input  logic [7:0]          regAddr,
  input  logic                regWe,
  input  logic [W-1:0]        regWdata,
  input  logic                irqAck,
  input  logic [N-1:0]        ovf,
  input  logic [N-1:0][W-1:0] cntVal,
  output cntStrobe_t          strb,
  output logic [W-1:0]        regRdata,
  output logic                irqReq
);
  localparam int WORD_W   = 4;
  localparam int LCL_BASE = 2;
  localparam int CNT_BASE = LCL_BASE + N;

  logic [N-1:0]         enQ, suQ, irqEnQ, frozenQ, statusQ;
  logic [N-1:0][SW-1:0] selQ;
  logic [N-1:0]         isLcl, isCnt, evSel;
  logic [NEVT-1:0]      evtVec;
  logic [WORD_W-1:0]    wordIdx;
  logic                 inWin, isGlb, isStat;

  assign inWin   = (regAddr[7:6] == 2'b11) && (regAddr[1:0] == 2'b00);
  assign wordIdx = regAddr[5:2];
  assign isGlb   = inWin && (wordIdx == WORD_W'(0));
  assign isStat  = inWin && (wordIdx == WORD_W'(1));
  assign evtVec  = {evtIn, 1'b1};

  for (genvar k = 0; k < N; k++) begin : g_sel
    assign isLcl[k] = inWin && (wordIdx == WORD_W'(LCL_BASE + k));
    assign isCnt[k] = inWin && (wordIdx == WORD_W'(CNT_BASE + k));
    if (k == 0) begin : g_time
      assign evSel[k] = 1'b1;
    end else begin : g_evt
      assign evSel[k] = evtVec[selQ[k]];
    end
    assign strb.inc[k]  = enQ[k] & ~frozenQ[k] & (suQ[k] | ~superMode) & evSel[k];
    assign strb.zero[k] = regWe & ((isLcl[k] & regWdata[LC_CLR]) | (isGlb & regWdata[GC_RST]));
    assign strb.load[k] = regWe & isCnt[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= '0; suQ <= '0; irqEnQ <= '0; selQ <= '0;
      frozenQ <= '0; statusQ <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (regWe && isLcl[k]) begin
          enQ[k]    <= regWdata[LC_EN];
          suQ[k]    <= regWdata[LC_SU];
          irqEnQ[k] <= regWdata[LC_IRQ];
          selQ[k]   <= regWdata[LC_SEL_LSB +: SW];
        end else if (regWe && isGlb && regWdata[GC_EN]) begin
          enQ[k] <= 1'b1;
        end
      end
      frozenQ <= irqAck ? ovf : (frozenQ | ovf);
      statusQ <= irqAck ? (ovf & irqEnQ) : (statusQ | (ovf & irqEnQ));
    end
  end

  assign irqReq = |statusQ;

  always_comb begin
    regRdata = '0;
    if (isStat) regRdata[N-1:0] = statusQ;
    for (int k = 0; k < N; k++) begin
      if (isLcl[k]) begin
        regRdata[LC_EN]              = enQ[k];
        regRdata[LC_SU]              = suQ[k];
        regRdata[LC_IRQ]             = irqEnQ[k];
        regRdata[LC_SEL_LSB +: SW]   = selQ[k];
      end
      if (isCnt[k]) regRdata = cntVal[k];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_ast
    AST_STATUS_ON_OVF: assert property (@(posedge clk) disable iff (!rstN)
      (ovf[k] && irqEnQ[k]) |=> statusQ[k]); // R10
    AST_FREEZE_AFTER_OVF: assert property (@(posedge clk) disable iff (!rstN)
      ovf[k] |=> !strb.inc[k]); // R9
    AST_SUPER_GATED: assert property (@(posedge clk) disable iff (!rstN)
      (superMode && !suQ[k]) |-> !strb.inc[k]); // R5
  end

  AST_CYCLE_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (enQ[0] && !frozenQ[0] && (suQ[0] || !superMode)) |-> strb.inc[0]); // R4
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && ovf == '0) |=> (frozenQ == '0 && statusQ == '0 && !irqReq)); // R11
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(|ovf)); // R10
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EVT-2:0]  evtIn,
  input  logic                superMode,
  input  logic [7:0]          regAddr,
  input  logic                regWe,
  input  logic [CNT_W-1:0]    regWdata,
  output logic [CNT_W-1:0]    regRdata,
  input  logic                irqAck,
  output logic                irqReq
);
  cntStrobe_t                      strb;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cntVal;
  logic [NUM_CNT-1:0]              ovf;

  pmu_ctrl #(.N(NUM_CNT), .W(CNT_W), .SW(SEL_W), .NEVT(NUM_EVT)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .superMode(superMode),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .irqAck(irqAck),
    .ovf(ovf), .cntVal(cntVal), .strb(strb), .regRdata(regRdata), .irqReq(irqReq)
  );

  pmu_datapath #(.N(NUM_CNT), .W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadData(regWdata),
    .cntVal(cntVal), .ovf(ovf)
  );
endmodule

// File: tb/perf_mon_unit_test.sv
module perf_mon_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  evtIn = '0;
  logic        superMode = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqAck = 1'b0;
  logic        irqReq;

  int nChecks = 0;
  int nFail = 0;

  perf_mon_unit uut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .superMode(superMode),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .irqAck(irqAck), .irqReq(irqReq)
  );

  always #2 clk = ~clk;

  // bits 7:1 event pulses, bit 0 supervisor flag
  localparam logic [7:0] VECS [12] = '{
    8'b1111111_0, 8'b1111111_1, 8'b0101010_0, 8'b1010101_1,
    8'b0000000_0, 8'b1100110_1, 8'b0011001_0, 8'b1111110_1,
    8'b0000010_1, 8'b1000000_0, 8'b0111100_1, 8'b1001011_0
  };

  function automatic logic [7:0] lclAddr(input int k); return 8'(8'hC8 + 4*k); endfunction
  function automatic logic [7:0] cntAddr(input int k); return 8'(8'hE4 + 4*k); endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(regRdata, exp, tag);
  endtask

  task automatic pulseEvt(input logic [6:0] e);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] expCnt [7];
    for (int k = 0; k < 7; k++) expCnt[k] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({31'b0, irqReq}, 32'd0, "R1 irqReq");
    for (int k = 0; k < 7; k++) rdChk(cntAddr(k), 32'd0, "R1 counter");
    rdChk(lclAddr(4), 32'd0, "R1 local ctrl");
    rdChk(8'hC4, 32'd0, "R1 status");

    // R2 decode, R12 status write ignored
    rdChk(8'h40, 32'd0, "R2 outside window");
    rdChk(8'hC2, 32'd0, "R2 misaligned");
    @(negedge clk);
    wrReg(8'hC4, 32'h7F);
    rdChk(8'hC4, 32'd0, "R12 status write");

    // R3/R5 configure counters 1..6: select code k+1, supervisor bit = k odd
    @(negedge clk);
    for (int k = 1; k < 7; k++)
      wrReg(lclAddr(k), 32'(1 | ((k % 2) << 2) | ((k + 1) << 4)));
    rdChk(lclAddr(3), 32'h45, "R3 local readback");

    // R3/R5 stimulus table
    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      evtIn = VECS[v][7:1];
      superMode = VECS[v][0];
      for (int k = 1; k < 7; k++)
        if (VECS[v][k+1] && ((k % 2) == 1 || !VECS[v][0])) expCnt[k] = expCnt[k] + 1;
    end
    @(negedge clk);
    evtIn = '0; superMode = 1'b0;
    for (int k = 1; k < 7; k++) rdChk(cntAddr(k), expCnt[k], "R3 R5 table count");

    // R4 counter 0 counts cycles with select set to 5
    @(negedge clk);
    wrReg(lclAddr(0), 32'h51);
    repeat (5) @(negedge clk);
    wrReg(lclAddr(0), 32'h50);
    rdChk(cntAddr(0), 32'd6, "R4 cycle count");

    // R6 global reset and enable
    @(negedge clk);
    wrReg(8'hC0, 32'h2);
    rdChk(cntAddr(0), 32'd0, "R6 reset cnt0");
    rdChk(cntAddr(4), 32'd0, "R6 reset cnt4");
    @(negedge clk);
    wrReg(lclAddr(5), 32'h64);
    wrReg(8'hC0, 32'h1);
    rdChk(lclAddr(5), 32'h65, "R6 enable all");
    @(negedge clk);
    wrReg(lclAddr(0), 32'h0);

    // R8 load, R3 increment, R7 clear beats event
    wrReg(cntAddr(3), 32'd10);
    rdChk(cntAddr(3), 32'd10, "R8 load");
    @(negedge clk);
    pulseEvt(7'b0001000);
    rdChk(cntAddr(3), 32'd11, "R3 single event");
    @(negedge clk);
    evtIn = 7'b0001000;
    wrReg(lclAddr(3), 32'h47);
    evtIn = '0;
    rdChk(cntAddr(3), 32'd0, "R7 clear over event");
    rdChk(lclAddr(3), 32'h45, "R7 clear reads zero");

    // R9/R10 overflow with interrupt
    @(negedge clk);
    wrReg(lclAddr(1), 32'h2D);
    wrReg(cntAddr(1), 32'hFFFF_FFFF);
    pulseEvt(7'b0000010);
    rdChk(cntAddr(1), 32'd0, "R9 wrap to zero");
    chk({31'b0, irqReq}, 32'd1, "R10 irqReq");
    rdChk(8'hC4, 32'h02, "R10 status bit");
    @(negedge clk);
    wrReg(8'hC4, 32'h0);
    rdChk(8'hC4, 32'h02, "R12 status kept");
    @(negedge clk);
    pulseEvt(7'b0000010);
    rdChk(cntAddr(1), 32'd0, "R9 frozen");

    // R9/R10 overflow without interrupt
    @(negedge clk);
    wrReg(lclAddr(2), 32'h31);
    wrReg(cntAddr(2), 32'hFFFF_FFFF);
    pulseEvt(7'b0000100);
    rdChk(cntAddr(2), 32'd0, "R9 wrap no irq");
    rdChk(8'hC4, 32'h02, "R10 no status without enable");

    // R11 acknowledge
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    #1;
    chk({31'b0, irqReq}, 32'd0, "R11 irqReq low");
    rdChk(8'hC4, 32'd0, "R11 status cleared");
    @(negedge clk);
    pulseEvt(7'b0000110);
    rdChk(cntAddr(1), 32'd1, "R11 release cnt1");
    rdChk(cntAddr(2), 32'd1, "R11 release cnt2");

    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule